// File: doc/BRIEF.md
# Lookahead Refill Scheduler for Head FIFOs

This block chooses which per-queue head FIFO gets the next block refill from bulk memory. Byte read requests arrive at most one per cycle, each tagged with a queue number. They enter a delay line of `X` stages and are served only when they leave it. While requests sit in the delay line, the block already knows the demand each queue will face in the next `X` cycles.

Once every `B` cycles the block makes a refill decision. It compares the pending demand in the delay line against the byte count held by each head FIFO. The block counts requests from the oldest entry forward. A queue becomes at risk at the first position where its running request count exceeds its level. If any queue is at risk, the one that reaches that point soonest gets `B` bytes. If no queue is at risk, the least-filled FIFO that still has room for a whole block gets them.

The block keeps the byte level of each head FIFO. It reports the request being served, the refill choice, and a flag for a serve that finds its FIFO empty. Data storage and the bulk memory port lie outside the block. A refill is taken to land on the same clock edge that the decision is made.

Top module: `lookahead_refill_sel`

## Requirements
- R1: A request sampled with `req_valid`=1 at a rising edge appears on `serve_valid`/`serve_queue` during the cycle that follows the X-th rising edge after it was sampled. Requests are served in arrival order. A cycle with no request produces a cycle with `serve_valid`=0 X cycles later.
- R2: `sel_valid` can be 1 only in the cycle right after reset release and then in every B-th cycle after it. It is 0 in all other cycles.
- R3: In a decision cycle, queue q is at risk when a position k exists at which the running count of requests for q exceeds the level of q. The count runs over the delay line from the oldest entry (k=0, the entry served at the coming edge) towards the newest. The first such k is the queue's risk time. If any queue is at risk, `sel_valid`=1, `sel_urgent`=1, and `sel_queue` is the at-risk queue with the smallest risk time. This choice ignores free space.
- R4: Ties between equal risk times, and ties between equal levels in the fallback choice, go to the lowest queue number.
- R5: In a decision cycle with no queue at risk, the refill goes to the queue with the lowest level among those whose level is at most CAP-B, with `sel_urgent`=0. If no queue has that much room, `sel_valid`=0.
- R6: At each rising edge, the level of queue q gains B when the refill goes to q. It loses 1 when a request for q is served without underrun. The level of q is carried on `level_flat[q*LW +: LW]`, with LW = $clog2(X+B+CAP+1).
- R7: `underrun` is 1 when the served request finds a level of 0 and the same edge brings no refill to that queue. Under the bench stimulus it never rises.
- R8: During reset and right after release, all levels are 0, the delay line is empty, `serve_valid`=0, and the first decision picks queue 0 with `sel_urgent`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A byte request is presented this cycle |
| req_queue | input | QW | Queue number of the request |
| serve_valid | output | 1 | A request leaves the delay line at the coming edge |
| serve_queue | output | QW | Queue of the request being served |
| sel_valid | output | 1 | A refill of B bytes lands at the coming edge |
| sel_queue | output | QW | Queue receiving the refill |
| sel_urgent | output | 1 | The refill was chosen because a queue is at risk |
| underrun | output | 1 | The served request found its FIFO empty |
| level_flat | output | Q*LW | Byte level of each head FIFO, queue q in slice q |

## Verification
An error in the delay line shows up on `serve_queue` exactly X cycles after the request went in. An error in a level shows up on `level_flat` on the next edge. Either error also tilts the next decision toward the wrong queue within B cycles. A wrong risk-time comparison or tie order appears directly on `sel_queue` or `sel_urgent` in the decision cycle where it matters. The bench therefore compares every output against a behavioural model in every cycle. The failing cycle then sits at most B cycles after the fault is first observable.

// File: rtl/lookahead_refill_sel.sv
module lookahead_refill_sel #(
  parameter int Q   = 4,
  parameter int B   = 4,
  parameter int X   = 16,
  parameter int CAP = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic [(Q > 1 ? $clog2(Q) : 1)-1:0]   req_queue,
  output logic                                 serve_valid,
  output logic [(Q > 1 ? $clog2(Q) : 1)-1:0]   serve_queue,
  output logic                                 sel_valid,
  output logic [(Q > 1 ? $clog2(Q) : 1)-1:0]   sel_queue,
  output logic                                 sel_urgent,
  output logic                                 underrun,
  output logic [Q*$clog2(X+B+CAP+1)-1:0]       level_flat
);
  localparam int QW = (Q > 1) ? $clog2(Q) : 1;
  localparam int LW = $clog2(X + B + CAP + 1);
  localparam int TW = $clog2(X);
  localparam int PW = (B > 1) ? $clog2(B) : 1;
  localparam logic [LW-1:0] BLK  = LW'(B);
  localparam logic [LW-1:0] ROOM = LW'(CAP - B);

  logic [X-1:0]  dl_v;
  logic [QW-1:0] dl_q [X];
  logic [LW-1:0] lvl  [Q];
  logic [PW-1:0] phase;

  logic [Q-1:0]  risk;
  logic [TW-1:0] rtime [Q];
  logic          urg;
  logic [QW-1:0] urg_q;
  logic          roomy;
  logic [QW-1:0] fb_q;
  logic [LW-1:0] fb_lvl;
  logic          decide;

  always_comb begin
    logic [LW-1:0] cnt;
    for (int q = 0; q < Q; q++) begin
      risk[q]  = 1'b0;
      rtime[q] = '0;
      cnt      = '0;
      for (int k = 0; k < X; k++) begin
        if (dl_v[X-1-k] && dl_q[X-1-k] == QW'(q)) cnt = cnt + 1'b1;
        if (!risk[q] && cnt > lvl[q]) begin
          risk[q]  = 1'b1;
          rtime[q] = TW'(k);
        end
      end
    end
  end

  always_comb begin
    urg   = 1'b0;
    urg_q = '0;
    for (int q = 0; q < Q; q++)
      if (risk[q] && (!urg || rtime[q] < rtime[urg_q])) begin
        urg   = 1'b1;
        urg_q = QW'(q);
      end
  end

  always_comb begin
    roomy  = 1'b0;
    fb_q   = '0;
    fb_lvl = '0;
    for (int q = 0; q < Q; q++)
      if (lvl[q] <= ROOM && (!roomy || lvl[q] < fb_lvl)) begin
        roomy  = 1'b1;
        fb_q   = QW'(q);
        fb_lvl = lvl[q];
      end
  end

  assign decide      = (phase == '0);
  assign sel_valid   = decide && (urg || roomy);
  assign sel_urgent  = decide && urg;
  assign sel_queue   = urg ? urg_q : fb_q;
  assign serve_valid = dl_v[X-1];
  assign serve_queue = dl_q[X-1];
  assign underrun    = serve_valid && lvl[serve_queue] == '0 &&
                       !(sel_valid && sel_queue == serve_queue);

  for (genvar g = 0; g < Q; g++) begin : g_lvl
    assign level_flat[g*LW +: LW] = lvl[g];
    always_ff @(posedge clk) begin
      if (!rst_n) lvl[g] <= '0;
      else lvl[g] <= lvl[g]
                   + ((sel_valid && sel_queue == QW'(g)) ? BLK : '0)
                   - ((serve_valid && serve_queue == QW'(g) && !underrun) ? LW'(1) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_v  <= '0;
      phase <= '0;
      for (int k = 0; k < X; k++) dl_q[k] <= '0;
    end else begin
      dl_v  <= {dl_v[X-2:0], req_valid};
      dl_q[0] <= req_queue;
      for (int k = 1; k < X; k++) dl_q[k] <= dl_q[k-1];
      phase <= (phase == PW'(B - 1)) ? '0 : phase + 1'b1;
    end
  end
endmodule

module lookahead_refill_sel_chk #(
  parameter int Q = 4, parameter int B = 4, parameter int X = 16, parameter int CAP = 12,
  parameter int QW = 2, parameter int LW = 6
) (
  input logic clk, input logic rst_n,
  input logic serve_valid, input logic [QW-1:0] serve_queue,
  input logic sel_valid, input logic [QW-1:0] sel_queue,
  input logic sel_urgent, input logic underrun,
  input logic [Q*LW-1:0] level_flat
);
  AST_SEL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> !sel_valid); // R2
  AST_URGENT_IMPLIES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_urgent |-> sel_valid); // R3
  AST_FALLBACK_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_urgent) |-> level_flat[sel_queue*LW +: LW] <= LW'(CAP - B)); // R5
  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    !underrun); // R7
  for (genvar g = 0; g < Q; g++) begin : g_a
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(!rst_n) |-> level_flat[g*LW +: LW] == $past(level_flat[g*LW +: LW])
        + (($past(sel_valid) && $past(sel_queue) == QW'(g)) ? LW'(B) : LW'(0))
        - (($past(serve_valid) && $past(serve_queue) == QW'(g) && !$past(underrun)) ? LW'(1) : LW'(0))); // R6
  end
endmodule

bind lookahead_refill_sel lookahead_refill_sel_chk #(.Q(Q), .B(B), .X(X), .CAP(CAP), .QW(QW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .serve_valid(serve_valid), .serve_queue(serve_queue),
  .sel_valid(sel_valid), .sel_queue(sel_queue), .sel_urgent(sel_urgent),
  .underrun(underrun), .level_flat(level_flat));

// File: tb/lookahead_refill_sel_tb.sv
module lookahead_refill_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4, B = 4, X = 16, CAP = 12;
  localparam int QW = 2;
  localparam int LW = $clog2(X + B + CAP + 1);

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [QW-1:0] req_queue = '0;
  logic serve_valid, sel_valid, sel_urgent, underrun;
  logic [QW-1:0] serve_queue, sel_queue;
  logic [Q*LW-1:0] level_flat;

  int n_checks = 0, n_fail = 0;
  int m_dl[X];
  int m_lvl[Q];
  int m_ph;
  int e_sv, e_sq, e_selv, e_selq, e_urg, e_und;

  always #(CLK_PERIOD/2) clk = ~clk;

  lookahead_refill_sel #(.Q(Q), .B(B), .X(X), .CAP(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_queue(req_queue),
    .serve_valid(serve_valid), .serve_queue(serve_queue),
    .sel_valid(sel_valid), .sel_queue(sel_queue), .sel_urgent(sel_urgent),
    .underrun(underrun), .level_flat(level_flat));

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    for (int k = 0; k < X; k++) m_dl[k] = -1;
    for (int q = 0; q < Q; q++) m_lvl[q] = 0;
    m_ph = 0;
  endtask

  task automatic m_eval();
    int best_t, cand;
    e_sv = (m_dl[X-1] >= 0) ? 1 : 0;
    e_sq = e_sv ? m_dl[X-1] : 0;
    e_urg = 0; e_selv = 0; e_selq = 0; best_t = X + 1;
    for (int q = 0; q < Q; q++) begin
      int cum = 0, t = -1;
      for (int k = 0; k < X && t < 0; k++) begin
        if (m_dl[X-1-k] == q) cum++;
        if (cum > m_lvl[q]) t = k;
      end
      if (t >= 0 && t < best_t) begin best_t = t; cand = q; e_urg = 1; end
    end
    if (m_ph == 0) begin
      if (e_urg) begin e_selv = 1; e_selq = cand; end
      else begin
        int lo = 1 << 30;
        for (int q = 0; q < Q; q++)
          if (m_lvl[q] <= CAP - B && m_lvl[q] < lo) begin lo = m_lvl[q]; e_selq = q; e_selv = 1; end
      end
    end else e_urg = 0;
    e_und = (e_sv && m_lvl[e_sq] == 0 && !(e_selv && e_selq == e_sq)) ? 1 : 0;
  endtask

  task automatic m_step(input int v, input int q);
    m_eval();
    if (e_selv) m_lvl[e_selq] += B;
    if (e_sv && !e_und) m_lvl[e_sq] -= 1;
    for (int k = X-1; k > 0; k--) m_dl[k] = m_dl[k-1];
    m_dl[0] = v ? q : -1;
    m_ph = (m_ph + 1) % B;
  endtask

  task automatic compare_all();
    m_eval();
    check("R1 serve_valid", serve_valid, e_sv);
    if (e_sv) check("R1 serve_queue", serve_queue, e_sq);
    check("R2/R5 sel_valid", sel_valid, e_selv);
    if (e_selv) check("R3/R4 sel_queue", sel_queue, e_selq);
    check("R3 sel_urgent", sel_urgent, e_urg);
    check("R7 underrun", underrun, e_und);
    check("R7 model underrun", e_und, 0);
    for (int q = 0; q < Q; q++)
      check("R6 level", int'(level_flat[q*LW +: LW]), m_lvl[q]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cur_v = 0, cur_q = 0, nv, nq, run = 0, rq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 level q0 in reset", int'(level_flat[0 +: LW]), 0);
    rst_n = 1'b1;
    m_reset();
    // R8: state right after release
    m_eval();
    check("R8 serve_valid", serve_valid, 0);
    check("R8 first sel_valid", sel_valid, 1);
    check("R8 first sel_queue", sel_queue, 0);
    check("R8 first sel_urgent", sel_urgent, 0);
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      m_step(cur_v, cur_q);
      compare_all();
      if (c < 300)       begin nv = 1; nq = 2; end               // single-queue stream
      else if (c < 600)  begin nv = 1; nq = c % Q; end           // round robin
      else if (c < 700)  begin nv = 0; nq = 0; end               // idle
      else if (c < 3000) begin                                   // bursts on one queue
        if (run == 0) begin run = 1 + ($urandom % 12); rq = $urandom % Q; end
        run--; nv = 1; nq = rq;
      end else if (c < 5900) begin                               // sparse random mix
        nv = (($urandom % 4) != 0) ? 1 : 0; nq = $urandom % Q;
      end else begin nv = 0; nq = 0; end
      req_valid = nv[0];
      req_queue = QW'(nq);
      cur_v = nv; cur_q = nq;
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule